// File: doc/BRIEF.md
# HDMI Transmitter Hot-Plug and Register Bridge

This block sits in front of an HDMI transmitter controller and gives the CPU one small window onto it. The only signal it watches by itself is the hot-plug-detect line. That line is brought into the clock domain and filtered by a programmable stability counter. Every accepted change in either direction is latched as its own interrupt cause. The controller's own interrupt request is latched as a third cause. The three causes are combined, through a mask, into one interrupt line toward the CPU.

The CPU reaches everything through two ports. The first is an address register. The second is a data window whose accesses go to the location that the address names. When the top address bit is set, a data access passes to the controller's register space with the lower address bits. When it is clear, the access stays in the bridge's own small register set. Read data comes back registered, one cycle after the read strobe.

Top module: `txw_top`

## Requirements
- R1: After reset, the cause bits and the mask are zero, the debounce limit equals the parameter DEB_RESET (4), the address register is zero, and both `irq` and `cpu_rvalid` are low.
- R2: A change on `hpd_in` is accepted only when the synchronised level differs from the accepted level for more than debounce-limit consecutive cycles. A shorter pulse leaves the cause bits and the accepted level unchanged.
- R3: An accepted low-to-high change sets cause bit 0. An accepted high-to-low change sets cause bit 1. Each bit stays set until software clears it.
- R4: Every cycle in which `ctl_irq` is high sets cause bit 2.
- R5: A data write to local offset 0 clears each cause bit written as 1 and leaves the bits written as 0. If a cause is raised in the same cycle as its clear, the cause wins and the bit stays set.
- R6: `irq` is high exactly when some cause bit is set whose mask bit is also set. The mask is at local offset 1, bits 2:0.
- R7: A write with `cpu_reg`=0 loads the address register from the low 16 bits of `cpu_wdata`. A read with `cpu_reg`=0 returns the address register.
- R8: With address bit 15 set, data writes and reads drive `ctl_wr`/`ctl_rd` with `ctl_addr` = address bits 14:0 and leave local registers untouched. With bit 15 clear, the controller strobes stay low.
- R9: `cpu_rvalid` is high in the cycle after any read strobe, and `cpu_rdata` then holds the selected value.
- R10: Local offset 3 is read-only. Bit 0 holds the accepted hot-plug level and bit 1 holds the synchronised raw level.
- R11: Local offset 2 holds the debounce limit (16 bits, upper write bits dropped). Local offsets above 3 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpd_in | input | 1 | Asynchronous hot-plug-detect level |
| ctl_irq | input | 1 | Interrupt request from the transmitter controller |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_reg | input | 1 | 0 selects the address register, 1 selects the data window |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_addr | output | 15 | Controller register address |
| ctl_wdata | output | 32 | Controller write data |
| ctl_rdata | input | 32 | Controller read data, valid in the strobe cycle |
| irq | output | 1 | Masked, combined interrupt to the CPU |

## Verification
A software clear of the cause register can land in the same clock edge as a new cause. The bench provokes this by holding `ctl_irq` high across a write of 1 to cause bit 2, and then reading the cause register. The bit must still be set, and a second clear, made after the request has dropped, must leave it zero. The debounce filter and the cause latches interact in a similar way. A glitch shorter than the programmed limit arrives while the cause bits are freshly cleared, and the bench requires all three bits to remain zero afterwards.

// File: rtl/txw_pkg.sv
package txw_pkg;
   localparam int unsigned NCAUSE     = 3;
   localparam int unsigned CAUSE_RISE = 0;
   localparam int unsigned CAUSE_FALL = 1;
   localparam int unsigned CAUSE_CTL  = 2;

   typedef enum logic [1:0] {
      OFS_CAUSE    = 2'd0,
      OFS_MASK     = 2'd1,
      OFS_DEBOUNCE = 2'd2,
      OFS_LEVEL    = 2'd3
   } loc_ofs_e;
endpackage

// File: rtl/txw_hpd_filter.sv
module txw_hpd_filter #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned DEB_W        = 16,
   parameter bit          USE_DEBOUNCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hpd_async,
   input  logic [DEB_W-1:0] deb_limit,
   output logic             hpd_sync,
   output logic             hpd_level,
   output logic             rise_pulse,
   output logic             fall_pulse
);
   logic [SYNC_STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], hpd_async};
   end
   assign hpd_sync = chain_q[SYNC_STAGES-1];

   generate
      if (USE_DEBOUNCE) begin : g_deb
         logic [DEB_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q      <= '0;
               hpd_level  <= 1'b0;
               rise_pulse <= 1'b0;
               fall_pulse <= 1'b0;
            end else begin
               rise_pulse <= 1'b0;
               fall_pulse <= 1'b0;
               if (hpd_sync == hpd_level) begin
                  cnt_q <= '0;
               end else if (cnt_q >= deb_limit) begin
                  cnt_q      <= '0;
                  hpd_level  <= hpd_sync;
                  rise_pulse <= hpd_sync;
                  fall_pulse <= !hpd_sync;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hpd_level  <= 1'b0;
               rise_pulse <= 1'b0;
               fall_pulse <= 1'b0;
            end else begin
               hpd_level  <= hpd_sync;
               rise_pulse <= hpd_sync & ~hpd_level;
               fall_pulse <= ~hpd_sync & hpd_level;
            end
         end
      end
   endgenerate

   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pulse && fall_pulse)); // R3
   AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |-> hpd_level); // R3
   AST_LEVEL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (hpd_level != $past(hpd_level)) |-> ($past(hpd_sync) == hpd_level)); // R2
endmodule

// File: rtl/txw_irq_ctrl.sv
module txw_irq_ctrl #(
   parameter int unsigned NC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] set_vec,
   input  logic          clr_wr,
   input  logic [NC-1:0] clr_vec,
   input  logic          mask_wr,
   input  logic [NC-1:0] mask_wdata,
   output logic [NC-1:0] cause_q,
   output logic [NC-1:0] mask_q,
   output logic          irq
);
   logic [NC-1:0] clr_eff;

   always_comb clr_eff = clr_wr ? clr_vec : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '0;
      end else begin
         cause_q <= (cause_q & ~clr_eff) | set_vec;
         if (mask_wr) mask_q <= mask_wdata;
      end
   end

   assign irq = |(cause_q & mask_q);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R5
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0)); // R5
   AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|cause_q)); // R6
endmodule

// File: rtl/txw_reg_bridge.sv
module txw_reg_bridge
   import txw_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 32,
   parameter int unsigned DEB_W     = 16,
   parameter int unsigned DEB_RESET = 4,
   parameter int unsigned NC        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic             cpu_rd,
   input  logic             cpu_reg,
   input  logic [DW-1:0]    cpu_wdata,
   output logic [DW-1:0]    cpu_rdata,
   output logic             cpu_rvalid,
   output logic             ctl_wr,
   output logic             ctl_rd,
   output logic [AW-2:0]    ctl_addr,
   output logic [DW-1:0]    ctl_wdata,
   input  logic [DW-1:0]    ctl_rdata,
   input  logic [NC-1:0]    cause_q,
   input  logic [NC-1:0]    mask_q,
   input  logic             hpd_level,
   input  logic             hpd_sync,
   output logic             cause_wr,
   output logic             mask_wr,
   output logic [DEB_W-1:0] deb_limit
);
   logic [AW-1:0] addr_q;
   logic          far_space;
   logic          local_hit;
   loc_ofs_e      ofs;
   logic          data_wr, data_rd, loc_wr, deb_wr;
   logic [DW-1:0] loc_rdata, addr_ext;

   assign far_space = addr_q[AW-1];
   assign local_hit = (addr_q[AW-2:2] == '0);
   assign ofs       = loc_ofs_e'(addr_q[1:0]);
   assign data_wr   = cpu_wr & cpu_reg;
   assign data_rd   = cpu_rd & cpu_reg;
   assign loc_wr    = data_wr & ~far_space & local_hit;

   assign ctl_wr    = data_wr & far_space;
   assign ctl_rd    = data_rd & far_space;
   assign ctl_addr  = addr_q[AW-2:0];
   assign ctl_wdata = cpu_wdata;

   assign cause_wr  = loc_wr && (ofs == OFS_CAUSE);
   assign mask_wr   = loc_wr && (ofs == OFS_MASK);
   assign deb_wr    = loc_wr && (ofs == OFS_DEBOUNCE);

   always_comb begin
      addr_ext = '0;
      addr_ext[AW-1:0] = addr_q;
   end

   always_comb begin
      loc_rdata = '0;
      if (local_hit) begin
         unique case (ofs)
            OFS_CAUSE:    loc_rdata[NC-1:0]    = cause_q;
            OFS_MASK:     loc_rdata[NC-1:0]    = mask_q;
            OFS_DEBOUNCE: loc_rdata[DEB_W-1:0] = deb_limit;
            OFS_LEVEL:    loc_rdata[1:0]       = {hpd_sync, hpd_level};
            default:      loc_rdata            = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q     <= '0;
         deb_limit  <= DEB_W'(DEB_RESET);
         cpu_rdata  <= '0;
         cpu_rvalid <= 1'b0;
      end else begin
         if (cpu_wr && !cpu_reg) addr_q <= cpu_wdata[AW-1:0];
         if (deb_wr) deb_limit <= cpu_wdata[DEB_W-1:0];
         cpu_rvalid <= cpu_rd;
         if (cpu_rd) begin
            if (!cpu_reg)      cpu_rdata <= addr_ext;
            else if (far_space) cpu_rdata <= ctl_rdata;
            else               cpu_rdata <= loc_rdata;
         end
      end
   end

   AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> cpu_rvalid); // R9
   AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && loc_wr)); // R8
   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !cpu_reg) |=> (addr_q == $past(cpu_wdata[AW-1:0]))); // R7
endmodule

// File: rtl/txw_top.sv
module txw_top
   import txw_pkg::*;
#(
   parameter int unsigned AW           = 16,
   parameter int unsigned DW           = 32,
   parameter int unsigned DEB_W        = 16,
   parameter int unsigned DEB_RESET    = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          USE_DEBOUNCE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hpd_in,
   input  logic          ctl_irq,
   input  logic          cpu_wr,
   input  logic          cpu_rd,
   input  logic          cpu_reg,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_rvalid,
   output logic          ctl_wr,
   output logic          ctl_rd,
   output logic [AW-2:0] ctl_addr,
   output logic [DW-1:0] ctl_wdata,
   input  logic [DW-1:0] ctl_rdata,
   output logic          irq
);
   generate
      if (AW < 4)          begin : g_bad_aw   $error("AW must be at least 4");           end
      if (DW < AW)         begin : g_bad_dw   $error("DW must cover the address");       end
      if (DEB_W > DW)      begin : g_bad_deb  $error("DEB_W must fit in DW");            end
      if (DW < NCAUSE)     begin : g_bad_nc   $error("DW must cover the cause bits");    end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("at least two synchroniser flops"); end
   endgenerate

   logic              hpd_sync, hpd_level, rise_p, fall_p;
   logic [DEB_W-1:0]  deb_limit;
   logic [NCAUSE-1:0] cause_q, mask_q, set_vec;
   logic              cause_wr, mask_wr;

   always_comb begin
      set_vec             = '0;
      set_vec[CAUSE_RISE] = rise_p;
      set_vec[CAUSE_FALL] = fall_p;
      set_vec[CAUSE_CTL]  = ctl_irq;
   end

   txw_hpd_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_W       (DEB_W),
      .USE_DEBOUNCE(USE_DEBOUNCE)
   ) u_hpd (
      .clk       (clk),
      .rst_n     (rst_n),
      .hpd_async (hpd_in),
      .deb_limit (deb_limit),
      .hpd_sync  (hpd_sync),
      .hpd_level (hpd_level),
      .rise_pulse(rise_p),
      .fall_pulse(fall_p)
   );

   txw_irq_ctrl #(.NC(NCAUSE)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .clr_wr    (cause_wr),
      .clr_vec   (cpu_wdata[NCAUSE-1:0]),
      .mask_wr   (mask_wr),
      .mask_wdata(cpu_wdata[NCAUSE-1:0]),
      .cause_q   (cause_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   txw_reg_bridge #(
      .AW       (AW),
      .DW       (DW),
      .DEB_W    (DEB_W),
      .DEB_RESET(DEB_RESET),
      .NC       (NCAUSE)
   ) u_bridge (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_rd    (cpu_rd),
      .cpu_reg   (cpu_reg),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .cpu_rvalid(cpu_rvalid),
      .ctl_wr    (ctl_wr),
      .ctl_rd    (ctl_rd),
      .ctl_addr  (ctl_addr),
      .ctl_wdata (ctl_wdata),
      .ctl_rdata (ctl_rdata),
      .cause_q   (cause_q),
      .mask_q    (mask_q),
      .hpd_level (hpd_level),
      .hpd_sync  (hpd_sync),
      .cause_wr  (cause_wr),
      .mask_wr   (mask_wr),
      .deb_limit (deb_limit)
   );
endmodule

// File: tb/txw_top_tb.sv
module txw_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hpd_in = 1'b0;
   logic        ctl_irq = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_reg = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_rvalid;
   logic        ctl_wr, ctl_rd;
   logic [14:0] ctl_addr;
   logic [31:0] ctl_wdata, ctl_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int n_ctl_wr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   txw_top u_dut (
      .clk(clk), .rst_n(rst_n), .hpd_in(hpd_in), .ctl_irq(ctl_irq),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_addr(ctl_addr),
      .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .irq(irq)
   );

   // controller register-file stub
   logic [31:0] stub_mem [16];
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) stub_mem[i] <= '0;
      end else if (ctl_wr) begin
         stub_mem[ctl_addr[3:0]] <= ctl_wdata;
      end
   end
   assign ctl_rdata = stub_mem[ctl_addr[3:0]];

   always @(posedge clk) if (rst_n && ctl_wr) n_ctl_wr++;

   typedef struct packed {
      logic [15:0] a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{16'h8003, 32'hCAFE_0001, 32'hCAFE_0001},  // R8 controller space
      '{16'h800A, 32'h1234_5678, 32'h1234_5678},  // R8 controller space
      '{16'h0001, 32'hFFFF_FFFF, 32'h0000_0007},  // R6 mask width
      '{16'h0002, 32'h0001_2345, 32'h0000_2345},  // R11 debounce width
      '{16'h0007, 32'hDEAD_BEEF, 32'h0000_0000},  // R11 unmapped
      '{16'h0001, 32'h0000_0000, 32'h0000_0000},  // R6 mask off
      '{16'h0002, 32'h0000_0004, 32'h0000_0004}   // R11 restore limit
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_reg = sel; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic sel, output logic [31:0] q);
      @(negedge clk);
      cpu_rd = 1'b1; cpu_reg = sel;
      @(negedge clk);
      cpu_rd = 1'b0;
      q = cpu_rdata;
      chk("R9 rvalid", {31'd0, cpu_rvalid}, 32'd1);
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] q;
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 rvalid", {31'd0, cpu_rvalid}, 32'd0);
      bus_rd(1'b0, q); chk("R1 addr reg", q, 32'd0);
      bus_rd(1'b1, q); chk("R1 cause", q, 32'd0);
      bus_wr(1'b0, 32'h1); bus_rd(1'b1, q); chk("R1 mask", q, 32'd0);
      bus_wr(1'b0, 32'h2); bus_rd(1'b1, q); chk("R1 debounce", q, 32'd4);

      // table walk
      for (int v = 0; v < 7; v++) begin
         bus_wr(1'b0, {16'd0, VECS[v].a});
         bus_rd(1'b0, q); chk("R7 addr readback", q, {16'd0, VECS[v].a});
         bus_wr(1'b1, VECS[v].d);
         bus_rd(1'b1, q); chk("R8/R11 table read", q, VECS[v].e);
      end
      chk("R8 controller writes only from far space", n_ctl_wr, 32'd2);
      bus_wr(1'b0, 32'h8001); bus_rd(1'b1, q);
      chk("R8 local write kept off controller", q, 32'd0);

      // HPD rise
      bus_wr(1'b0, 32'h0);
      @(negedge clk); hpd_in = 1'b1;
      wait_cyc(12);
      bus_rd(1'b1, q); chk("R3 rise cause", q, 32'd1);
      chk("R6 masked irq low", {31'd0, irq}, 32'd0);
      bus_wr(1'b0, 32'h3); bus_rd(1'b1, q); chk("R10 level high", q, 32'd3);
      bus_wr(1'b0, 32'h1); bus_wr(1'b1, 32'h1);
      chk("R6 irq with mask", {31'd0, irq}, 32'd1);

      // W1C
      bus_wr(1'b0, 32'h0);
      bus_wr(1'b1, 32'h2); bus_rd(1'b1, q); chk("R5 zero bits kept", q, 32'd1);
      bus_wr(1'b1, 32'h1); bus_rd(1'b1, q); chk("R5 cleared", q, 32'd0);
      chk("R6 irq drops", {31'd0, irq}, 32'd0);

      // R2 glitch shorter than limit
      bus_wr(1'b0, 32'h2); bus_wr(1'b1, 32'd20);
      bus_wr(1'b0, 32'h0);
      @(negedge clk); hpd_in = 1'b0;
      wait_cyc(5);
      hpd_in = 1'b1;
      wait_cyc(30);
      bus_rd(1'b1, q); chk("R2 glitch ignored", q, 32'd0);
      bus_wr(1'b0, 32'h3); bus_rd(1'b1, q); chk("R2 level kept", q, 32'd3);

      // HPD fall
      bus_wr(1'b0, 32'h0);
      @(negedge clk); hpd_in = 1'b0;
      wait_cyc(40);
      bus_rd(1'b1, q); chk("R3 fall cause", q, 32'd2);
      bus_wr(1'b0, 32'h3); bus_rd(1'b1, q); chk("R10 level low", q, 32'd0);

      // controller interrupt
      bus_wr(1'b0, 32'h0); bus_wr(1'b1, 32'h7);
      bus_rd(1'b1, q); chk("R5 all cleared", q, 32'd0);
      @(negedge clk); ctl_irq = 1'b1;
      @(negedge clk); ctl_irq = 1'b0;
      bus_rd(1'b1, q); chk("R4 ctl cause", q, 32'd4);
      bus_wr(1'b0, 32'h1); bus_wr(1'b1, 32'h4);
      chk("R6 ctl irq out", {31'd0, irq}, 32'd1);

      // same-cycle set and clear
      bus_wr(1'b0, 32'h0);
      @(negedge clk); ctl_irq = 1'b1;
      bus_wr(1'b1, 32'h4);
      bus_rd(1'b1, q); chk("R5 set beats clear", q, 32'd4);
      @(negedge clk); ctl_irq = 1'b0;
      bus_wr(1'b1, 32'h4);
      bus_rd(1'b1, q); chk("R5 clear after drop", q, 32'd0);
      chk("R6 irq quiet", {31'd0, irq}, 32'd0);

      finish_run();
   end
endmodule